// File: doc/BRIEF.md
# Multi-Channel Monitoring ADC Sequencer

This block controls when conversions happen for a monitoring ADC that has one temperature channel and three voltage channels. The converter itself sits outside. The block divides the system clock down to a slower conversion clock. It waits a programmable settling time after choosing each input, then pulses a start strobe. When the converter returns its done strobe with a result, the block stores that result in a per-channel buffer. Temperature results are also compared against an overtemperature limit. Software configures the block through a small register bus and receives a level interrupt when an unmasked status bit is set.

The design has two reset inputs. The core reset returns all configuration and the per-channel done bits to their defaults. The overtemperature bit keeps its value through a core reset; only the power-up reset clears it. The result buffers have no reset at all. Once enabled, the block waits an activation period. It then runs conversion rounds continuously until it is disabled by software, by a core reset or by the idle request.

The sequencer is a seven-state machine:
- ST_OFF: idle.
- ST_ACTIVATE: counts the activation period.
- ST_PICK: presents the chosen channel and, for the temperature slot, latches the voltage-channel enables for the round.
- ST_SETTLE: counts 16 x delay conversion-clock ticks.
- ST_START: one-cycle start strobe.
- ST_WAIT: waits for the done strobe and captures the result.
- ST_STORE: writes the buffer and status, and picks the next slot.

The transitions are:
- OFF->ACTIVATE when enabled.
- ACTIVATE->PICK when the count expires.
- PICK->SETTLE when the delay is non-zero, or PICK->START when the delay is zero.
- SETTLE->START after the last tick.
- START->WAIT.
- WAIT->STORE on done.
- STORE->PICK.
- Any state returns to OFF when the enable bit is clear.

Top module: `adc_seq_ctrl`

Register map (address: content):
- 0: control. Bit 0 is the global enable; bits 3:1 enable voltage channels 1 to 3.
- 1: interrupt enables. Bits 3:0 cover the done bits; bit 4 covers overtemperature.
- 2: divider, in bits 5:0.
- 3: delays. Bits 3:0 hold the temperature delay; bits 7:4 hold the voltage delay.
- 4: overtemperature limit.
- 5, 6, 7: input select for voltage channels 1, 2 and 3, in bits 4:0.
- 8: status. Bits 3:0 are the done bits for temperature and voltage channels 1 to 3; bit 4 is overtemperature. Status bits are cleared by writing 1.
- 9 to 12: result buffers for temperature and voltage channels 1 to 3.

## Requirements
- R1: The divider register holds 4..63. A write of 0..3 stores 4. The conversion clock ticks once every divider-value system clocks.
- R2: A write to the divider register while the global enable (control bit 0) is 1 leaves the divider unchanged.
- R3: Before each start, the block waits delay x 16 x divider system clocks after choosing the channel. The delay is the temperature delay for channel 0 and the voltage delay otherwise. The start strobe is seen exactly 3 + delay x 16 x divider cycles after the done strobe of the previous conversion.
- R4: After a core reset, registers read as follows: control 0, interrupt enables 0, divider 63, delays 0xFF, limit 127, each input select 0x1F, done bits 0. irq and conv_start are 0.
- R5: A core reset keeps status bit 4 (overtemperature). A power-up reset clears it.
- R6: The result buffers keep their contents through a core reset.
- R7: The first start strobe after setting the enable comes no sooner than ACT_WAIT system clocks later.
- R8: Each round converts channel 0 (temperature, always) and then the enabled voltage channels in rising order; conv_chan gives the channel number 0..3. Voltage enables are latched when the round's temperature slot is chosen, so a channel enabled mid-round first appears in the following round.
- R9: Clearing control bit 0, asserting core_idle for one cycle, or a core reset each stop all further start strobes and leave control bit 0 reading 0.
- R10: A temperature result greater than or equal to the limit sets status bit 4. A lower result leaves it clear. irq rises when interrupt-enable bit 4 is set.
- R11: Storing a result writes buffer 9+channel and sets done bit [channel]. Writing 1 to a status bit clears it and leaves the other bits unchanged. irq is the OR of status bits ANDed with their interrupt enables.
- R12: While voltage channel k is being converted, conv_sel carries that channel's input select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_rst_n | input | 1 | Power-up reset, active low, asynchronous |
| core_rst_n | input | 1 | Core/warm reset, active low, asynchronous |
| core_idle | input | 1 | Core idle request, clears the enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt |
| conv_start | output | 1 | One-cycle conversion start |
| conv_chan | output | 2 | Channel being converted |
| conv_sel | output | 5 | Input select of the voltage channel being converted |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 8 | Converter result, valid with conv_done |

## Verification
The bench measures the exact gap from each done strobe to the next start, using a divider and delays drawn at random. A divider or settle counter that is off by one tick, or one that uses the wrong delay field, shifts this gap. The bench enables a voltage channel in the middle of a round. A design that does not latch the enables would insert that channel at once, and the observed channel order would show it. The bench places a temperature result one below the limit and then one equal to it. It also applies a core reset while the overtemperature bit is set and buffers hold data. A wrong comparison, or a bit or buffer placed in the wrong reset domain, would show up in the readback.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ACTIVATE,
        ST_PICK,
        ST_SETTLE,
        ST_START,
        ST_WAIT,
        ST_STORE
    } seq_state_e;

    localparam int A_CTRL   = 0;
    localparam int A_IEN    = 1;
    localparam int A_DIV    = 2;
    localparam int A_DLY    = 3;
    localparam int A_LIMIT  = 4;
    localparam int A_VSEL0  = 5;
    localparam int A_STATUS = 8;
    localparam int A_BUF0   = 9;

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DIV_W'(1);
    end

    // R1: counter stays inside the current division period
    p_cnt_in_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < div));

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 4,
    parameter int DIV_W   = 6,
    parameter int DLY_W   = 4,
    parameter int SEL_W   = 5,
    parameter int NUM_VCH = 3,
    localparam int NCH    = NUM_VCH + 1,
    localparam int CH_W   = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     core_rst_n,
    input  logic                     por_rst_n,
    input  logic                     core_idle,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     en,
    output logic [NUM_VCH-1:0]       ven,
    output logic [DIV_W-1:0]         div,
    output logic [DLY_W-1:0]         tdly,
    output logic [DLY_W-1:0]         vdly,
    output logic [NUM_VCH*SEL_W-1:0] vsel_flat,
    input  logic                     store_vld,
    input  logic [CH_W-1:0]          store_chan,
    input  logic [DATA_W-1:0]        store_data,
    output logic                     irq
);
    localparam int DIV_MIN = 4;

    logic                en_q;
    logic [NUM_VCH-1:0]  ven_q;
    logic [NCH:0]        ien_q;
    logic [DIV_W-1:0]    div_q;
    logic [DLY_W-1:0]    tdly_q, vdly_q;
    logic [DATA_W-1:0]   limit_q;
    logic [SEL_W-1:0]    vsel_q [NUM_VCH];
    logic [NCH-1:0]      done_q;
    logic                ot_q;
    logic [DATA_W-1:0]   buf_q [NCH];

    function automatic logic hit(input int a);
        return bus_wr && (bus_addr == ADDR_W'(a));
    endfunction

    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            en_q    <= 1'b0;
            ven_q   <= '0;
            ien_q   <= '0;
            div_q   <= '1;
            tdly_q  <= '1;
            vdly_q  <= '1;
            limit_q <= DATA_W'(127);
            done_q  <= '0;
        end else begin
            if (core_idle)
                en_q <= 1'b0;
            else if (hit(A_CTRL))
                en_q <= bus_wdata[0];
            if (hit(A_CTRL))
                ven_q <= bus_wdata[NUM_VCH:1];
            if (hit(A_IEN))
                ien_q <= bus_wdata[NCH:0];
            if (hit(A_DIV) && !en_q)
                div_q <= (bus_wdata[DIV_W-1:0] < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN)
                                                                 : bus_wdata[DIV_W-1:0];
            if (hit(A_DLY)) begin
                tdly_q <= bus_wdata[DLY_W-1:0];
                vdly_q <= bus_wdata[2*DLY_W-1:DLY_W];
            end
            if (hit(A_LIMIT))
                limit_q <= bus_wdata;
            for (int c = 0; c < NCH; c++) begin
                if (store_vld && store_chan == CH_W'(c))
                    done_q[c] <= 1'b1;
                else if (hit(A_STATUS) && bus_wdata[c])
                    done_q[c] <= 1'b0;
            end
        end
    end

    generate
        for (genvar v = 0; v < NUM_VCH; v++) begin : g_vsel
            always_ff @(posedge clk or negedge core_rst_n) begin
                if (!core_rst_n)
                    vsel_q[v] <= '1;
                else if (hit(A_VSEL0 + v))
                    vsel_q[v] <= bus_wdata[SEL_W-1:0];
            end
            assign vsel_flat[v*SEL_W +: SEL_W] = vsel_q[v];
        end
    endgenerate

    // overtemperature flag lives in the power-up domain
    always_ff @(posedge clk or negedge por_rst_n) begin
        if (!por_rst_n)
            ot_q <= 1'b0;
        else if (store_vld && store_chan == '0 && store_data >= limit_q)
            ot_q <= 1'b1;
        else if (hit(A_STATUS) && bus_wdata[NCH])
            ot_q <= 1'b0;
    end

    // result buffers carry no reset
    always_ff @(posedge clk) begin
        if (store_vld)
            buf_q[store_chan] <= store_data;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CTRL))   bus_rdata = DATA_W'({ven_q, en_q});
        if (bus_addr == ADDR_W'(A_IEN))    bus_rdata = DATA_W'(ien_q);
        if (bus_addr == ADDR_W'(A_DIV))    bus_rdata = DATA_W'(div_q);
        if (bus_addr == ADDR_W'(A_DLY))    bus_rdata = DATA_W'({vdly_q, tdly_q});
        if (bus_addr == ADDR_W'(A_LIMIT))  bus_rdata = limit_q;
        if (bus_addr == ADDR_W'(A_STATUS)) bus_rdata = DATA_W'({ot_q, done_q});
        for (int v = 0; v < NUM_VCH; v++)
            if (bus_addr == ADDR_W'(A_VSEL0 + v)) bus_rdata = DATA_W'(vsel_q[v]);
        for (int c = 0; c < NCH; c++)
            if (bus_addr == ADDR_W'(A_BUF0 + c)) bus_rdata = buf_q[c];
    end

    assign en   = en_q;
    assign ven  = ven_q;
    assign div  = div_q;
    assign tdly = tdly_q;
    assign vdly = vdly_q;
    assign irq  = |({ot_q, done_q} & ien_q);

    // R1: divider never leaves its legal range
    p_div_range_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
        div_q >= DIV_W'(DIV_MIN));
    // R2: divider frozen while enabled
    p_div_locked_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
        $past(en_q) |-> $stable(div_q));
    // R10: overtemperature only follows a temperature result at or above the limit
    p_ot_source_r10: assert property (@(posedge clk) disable iff (!por_rst_n || !core_rst_n)
        $rose(ot_q) |-> $past(store_vld && store_chan == '0 && store_data >= limit_q));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DLY_W    = 4,
    parameter int SEL_W    = 5,
    parameter int NUM_VCH  = 3,
    parameter int ACT_WAIT = 20000,
    localparam int NCH     = NUM_VCH + 1,
    localparam int CH_W    = $clog2(NCH),
    localparam int ACT_W   = $clog2(ACT_WAIT + 1),
    localparam int TCK_W   = DLY_W + 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [NUM_VCH-1:0]       ven,
    input  logic [DLY_W-1:0]         tdly,
    input  logic [DLY_W-1:0]         vdly,
    input  logic [NUM_VCH*SEL_W-1:0] vsel_flat,
    input  logic                     adc_tick,
    output logic                     div_run,
    output logic                     conv_start,
    output logic [CH_W-1:0]          conv_chan,
    output logic [SEL_W-1:0]         conv_sel,
    input  logic                     conv_done,
    input  logic [DATA_W-1:0]        conv_data,
    output logic                     store_vld,
    output logic [CH_W-1:0]          store_chan,
    output logic [DATA_W-1:0]        store_data
);
    seq_state_e          state_q, state_d;
    logic [ACT_W-1:0]    act_q;
    logic [TCK_W-1:0]    tck_q;
    logic [CH_W-1:0]     slot_q, slot_nx;
    logic [NUM_VCH-1:0]  snap_q;
    logic [DATA_W-1:0]   res_q;
    logic [TCK_W-1:0]    target;

    assign target = (slot_q == '0) ? {tdly, 4'b0000} : {vdly, 4'b0000};

    // next enabled voltage slot above the current one, else a new round
    always_comb begin
        slot_nx = '0;
        for (int k = NUM_VCH; k >= 1; k--)
            if (CH_W'(k) > slot_q && snap_q[k-1])
                slot_nx = CH_W'(k);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:      state_d = ST_ACTIVATE;
            ST_ACTIVATE: if (act_q == ACT_W'(ACT_WAIT - 1)) state_d = ST_PICK;
            ST_PICK:     state_d = (target == '0) ? ST_START : ST_SETTLE;
            ST_SETTLE:   if (adc_tick && tck_q == target - TCK_W'(1)) state_d = ST_START;
            ST_START:    state_d = ST_WAIT;
            ST_WAIT:     if (conv_done) state_d = ST_STORE;
            ST_STORE:    state_d = ST_PICK;
            default:     state_d = ST_OFF;
        endcase
        if (!en) state_d = ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= '0;
            tck_q  <= '0;
            slot_q <= '0;
            snap_q <= '0;
            res_q  <= '0;
        end else begin
            act_q <= (state_q == ST_ACTIVATE) ? act_q + ACT_W'(1) : '0;
            if (state_q != ST_SETTLE)
                tck_q <= '0;
            else if (adc_tick)
                tck_q <= tck_q + TCK_W'(1);
            if (state_q == ST_OFF)
                slot_q <= '0;
            else if (state_q == ST_STORE)
                slot_q <= slot_nx;
            if (state_q == ST_PICK && slot_q == '0)
                snap_q <= ven;
            if (state_q == ST_WAIT && conv_done)
                res_q <= conv_data;
        end
    end

    always_comb begin
        div_run    = (state_q == ST_SETTLE);
        conv_start = (state_q == ST_START);
        conv_chan  = slot_q;
        conv_sel   = '0;
        for (int k = 1; k <= NUM_VCH; k++)
            if (slot_q == CH_W'(k))
                conv_sel = vsel_flat[(k-1)*SEL_W +: SEL_W];
        store_vld  = (state_q == ST_STORE);
        store_chan = slot_q;
        store_data = res_q;
    end

    // R8: start strobe lasts a single cycle
    p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R8: each round opens with the temperature slot
    p_round_temp_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PICK && $past(state_q) == ST_ACTIVATE) |-> (slot_q == '0));
    // R8: slots only move upward within a round
    p_slot_rising_r8: assert property (@(posedge clk) disable iff (!rst_n)
        store_vld |=> (slot_q > $past(slot_q)) || (slot_q == '0));
    // R9: no start once disabled
    p_off_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !conv_start);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int ACT_WAIT = 20000
) (
    input  logic       clk,
    input  logic       por_rst_n,
    input  logic       core_rst_n,
    input  logic       core_idle,
    input  logic       bus_wr,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    output logic       conv_start,
    output logic [1:0] conv_chan,
    output logic [4:0] conv_sel,
    input  logic       conv_done,
    input  logic [7:0] conv_data
);
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int DIV_W   = 6;
    localparam int DLY_W   = 4;
    localparam int SEL_W   = 5;
    localparam int NUM_VCH = 3;
    localparam int CH_W    = $clog2(NUM_VCH + 1);

    logic                     rst_core_int;
    logic                     en, tick, div_run, store_vld;
    logic [NUM_VCH-1:0]       ven;
    logic [DIV_W-1:0]         div;
    logic [DLY_W-1:0]         tdly, vdly;
    logic [NUM_VCH*SEL_W-1:0] vsel_flat;
    logic [CH_W-1:0]          store_chan;
    logic [DATA_W-1:0]        store_data;

    assign rst_core_int = core_rst_n & por_rst_n;

    adc_seq_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W), .DLY_W(DLY_W),
        .SEL_W(SEL_W), .NUM_VCH(NUM_VCH)
    ) u_regs (
        .clk(clk), .core_rst_n(rst_core_int), .por_rst_n(por_rst_n),
        .core_idle(core_idle), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .en(en), .ven(ven),
        .div(div), .tdly(tdly), .vdly(vdly), .vsel_flat(vsel_flat),
        .store_vld(store_vld), .store_chan(store_chan), .store_data(store_data),
        .irq(irq)
    );

    adc_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_core_int), .run(div_run), .div(div), .tick(tick)
    );

    adc_seq_fsm #(
        .DATA_W(DATA_W), .DLY_W(DLY_W), .SEL_W(SEL_W), .NUM_VCH(NUM_VCH),
        .ACT_WAIT(ACT_WAIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_core_int), .en(en), .ven(ven), .tdly(tdly),
        .vdly(vdly), .vsel_flat(vsel_flat), .adc_tick(tick), .div_run(div_run),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_sel(conv_sel),
        .conv_done(conv_done), .conv_data(conv_data), .store_vld(store_vld),
        .store_chan(store_chan), .store_data(store_data)
    );

endmodule

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
    localparam int ACT = 300;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       por_rst_n = 1'b0, core_rst_n = 1'b0, core_idle = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       irq, conv_start, conv_done = 1'b0;
    logic [1:0] conv_chan;
    logic [4:0] conv_sel;
    logic [7:0] conv_data = '0;

    adc_seq_ctrl #(.ACT_WAIT(ACT)) uut (
        .clk(clk), .por_rst_n(por_rst_n), .core_rst_n(core_rst_n),
        .core_idle(core_idle), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_sel(conv_sel),
        .conv_done(conv_done), .conv_data(conv_data)
    );

    always #2.5 clk = ~clk;

    int nchk = 0, nerr = 0, cyc = 0;
    int nstart = 0, ndone = 0, pend = 0, cur_ch = 0;
    int st_cyc [64], st_ch [64], st_sel [64], dn_cyc [64];
    logic [7:0] stub_val [4];
    bit finished = 0;

    // converter stub and start/done monitor
    always @(negedge clk) begin
        cyc++;
        conv_done = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                conv_done = 1'b1;
                conv_data = stub_val[cur_ch];
                if (ndone < 64) dn_cyc[ndone] = cyc;
                ndone++;
            end
        end
        if (conv_start) begin
            if (nstart < 64) begin
                st_cyc[nstart] = cyc; st_ch[nstart] = conv_chan; st_sel[nstart] = conv_sel;
            end
            nstart++;
            cur_ch = conv_chan;
            pend = LAT;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_addr = 4'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    function automatic int exp_gap(input int ch, input int dv, input int td, input int vd);
        return 3 + ((ch == 0) ? td : vd) * 16 * dv;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int d, dv, td, vd, base, en_cyc, n0, v1_val;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4; i++) stub_val[i] = 8'($urandom);
        stub_val[0] = 8'($urandom % 127);
        repeat (4) @(negedge clk);
        por_rst_n = 1'b1; core_rst_n = 1'b1;

        // R4 reset defaults
        rd(0, d); chk("R4 ctrl", d, 0);
        rd(1, d); chk("R4 ien", d, 0);
        rd(2, d); chk("R4 div", d, 63);
        rd(3, d); chk("R4 dly", d, 8'hFF);
        rd(4, d); chk("R4 limit", d, 127);
        for (int v = 0; v < 3; v++) begin rd(5 + v, d); chk("R4 vsel", d, 8'h1F); end
        rd(8, d); chk("R4 status", d, 0);
        chk("R4 irq", int'(irq), 0);
        chk("R4 conv_start", int'(conv_start), 0);

        // R1 divider clamp
        wr(2, 2); rd(2, d); chk("R1 div clamp", d, 4);
        dv = 4 + int'($urandom % 4);
        td = int'($urandom % 3);
        vd = 1 + int'($urandom % 2);
        wr(2, dv); rd(2, d); chk("R1 div write", d, dv);
        wr(3, (vd << 4) | td);
        wr(5, 8'h03); wr(7, 8'h11);

        // run with voltage channels 1 and 3
        @(negedge clk); en_cyc = cyc;
        wr(0, 8'h0B);
        wr(2, 10); rd(2, d); chk("R2 div locked", d, dv);
        wait (nstart >= 1);
        chk("R7 activation lower", int'(st_cyc[0] - en_cyc >= ACT), 1);
        chk("R7 activation upper", int'(st_cyc[0] - en_cyc <= ACT + td * 16 * dv + 8), 1);
        wait (ndone >= 6);
        repeat (4) @(negedge clk);
        for (int i = 0; i < 6; i++) chk("R8 order", st_ch[i], (i % 3 == 0) ? 0 : (i % 3 == 1) ? 1 : 3);
        for (int i = 1; i < 6; i++) chk("R3 settle gap", st_cyc[i] - dn_cyc[i-1], exp_gap(st_ch[i], dv, td, vd));
        chk("R12 sel v1", st_sel[1], 8'h03);
        chk("R12 sel v3", st_sel[2], 8'h11);
        rd(9, d);  chk("R11 buf temp", d, stub_val[0]);
        rd(10, d); chk("R11 buf v1", d, stub_val[1]);
        rd(12, d); chk("R11 buf v3", d, stub_val[3]);
        rd(8, d);  chk("R11 done bits", d & 8'h0F, 8'b1011);
        chk("R10 no ot below", (d >> 4) & 1, 0);

        // R8 join next round
        wait (nstart >= 8);
        wr(0, 8'h0F);
        wait (nstart >= 13);
        chk("R8 join v3", st_ch[8], 3);
        chk("R8 join temp", st_ch[9], 0);
        chk("R8 join v1", st_ch[10], 1);
        chk("R8 join v2", st_ch[11], 2);
        chk("R8 join v3b", st_ch[12], 3);

        // R9 software disable
        wr(0, 0);
        repeat (LAT + 4) @(negedge clk);
        base = nstart;
        repeat (1500) @(negedge clk);
        chk("R9 sw disable", nstart, base);
        rd(0, d); chk("R9 ctrl clear", d & 1, 0);

        // R11 irq and write-1-to-clear
        rd(8, d); chk("R11 all done", d & 8'h0F, 8'hF);
        wr(1, 8'h02);
        @(negedge clk); chk("R11 irq set", int'(irq), 1);
        wr(8, 8'h02);
        rd(8, d); chk("R11 w1c", d, 8'h0D);
        chk("R11 irq clear", int'(irq), 0);

        // R9 idle request
        wr(0, 8'h01);
        @(negedge clk); core_idle = 1'b1;
        @(negedge clk); core_idle = 1'b0;
        base = nstart;
        repeat (ACT + 600) @(negedge clk);
        chk("R9 idle stop", nstart, base);
        rd(0, d); chk("R9 idle ctrl", d & 1, 0);

        // R10 overtemperature at the limit
        wr(4, 50); wr(1, 8'h10);
        stub_val[0] = 8'd49;
        n0 = ndone;
        wr(0, 8'h01);
        wait (ndone >= n0 + 1);
        repeat (4) @(negedge clk);
        rd(8, d); chk("R10 below limit", (d >> 4) & 1, 0);
        chk("R10 irq low", int'(irq), 0);
        stub_val[0] = 8'd50;
        wait (ndone >= n0 + 2);
        repeat (4) @(negedge clk);
        rd(8, d); chk("R10 at limit", (d >> 4) & 1, 1);
        chk("R10 irq", int'(irq), 1);
        rd(10, v1_val);

        // R5/R6/R9 core reset while running
        @(negedge clk); core_rst_n = 1'b0;
        @(negedge clk); core_rst_n = 1'b1;
        rd(8, d); chk("R5 ot kept", d, 8'h10);
        rd(0, d); chk("R9 core reset ctrl", d, 0);
        rd(9, d); chk("R6 buf temp kept", d, 50);
        rd(10, d); chk("R6 buf v1 kept", d, v1_val);
        base = nstart;
        repeat (ACT + 300) @(negedge clk);
        chk("R9 core reset stop", nstart, base);

        // R5 power-up reset clears it
        @(negedge clk); por_rst_n = 1'b0;
        @(negedge clk); por_rst_n = 1'b1;
        rd(8, d); chk("R5 por clears ot", d, 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule